// File: doc/BRIEF.md
# Inverter Gate Lockout and Operating Sequencer

This block protects a grid-tied inverter bridge and steps it through its start-up sequence. Every cycle it takes the magnitude of each signed phase-current sample and keeps the largest. If that peak is above a programmable limit, or if the active-low over-temperature line is low, every gate PWM line is forced to its off level at once. The path from the inputs to the gate outputs is purely combinational and does not pass through the state machine. A current trip also pulls an active-low interrupt line low. Either trip sets a sticky lockout. The lockout keeps the gates off until a clear command arrives while both fault sources are quiet.

Alongside the lockout, a sequencer walks the converter through these states: idle, insulation/leakage test, DC-link charge, relay closing, and running. It advances on status inputs from the rest of the converter. Each waiting state has its own cycle budget. An over-temperature trip or an expired budget sends the sequencer back to idle. A current trip parks it in a halt state that only a clear command can leave. The relay command is on only while closing or running, and it drops in the same cycle that any fault appears.

The current samples are sampled continuously, every cycle, with no valid/ready qualification. There is no back-pressure: the block consumes one sample set per clock and never stalls its source. All pins are plain control and status signals.

Top module: `inv_guard_seq`

## Requirements
- R1: Each phase sample is a signed two's-complement value whose magnitude is taken, -2048 giving 2048 for 12 bits. A trip occurs only when the largest magnitude is strictly greater than `oc_limit`. Equality does not trip.
- R2: In the same cycle that the current trip condition appears, `fault_irq_n` goes low and every bit of `pwm_out` is 0, with no clock edge needed.
- R3: A low `temp_fault_n` by itself forces every bit of `pwm_out` to 0 in the same cycle. It does not pull `fault_irq_n` low.
- R4: Both trips are latched, so `pwm_out` stays 0 after the source goes away. A `clr` high at a clock edge releases the latch only if neither source is active in that cycle. A `clr` given while a source is active is ignored.
- R5: `state` codes are 0 idle, 1 test, 2 charge, 3 closing, 4 running, 5 halt. The sequencer steps through them as follows:
  - idle to test at the first edge with no lockout;
  - test to charge when `chk_done` is high;
  - charge to closing when `prechg_done` is high;
  - closing to running when `relay_ack` is high.
- R6: `relay_cmd` is 1 only in states 3 and 4. It reads 0 in the same cycle that either fault source is active.
- R7: If the sequencer spends CHK_TMO, PCH_TMO or GC_TMO cycles in states 1, 2 or 3 respectively without the matching status input, it returns to idle on that edge.
- R8: A current trip moves the sequencer to halt (5) at the next edge. An over-temperature trip moves it to idle (0). Halt is left, to idle, only through an accepted `clr`.
- R9: While `rst_n` is low, `state` is 0, `relay_cmd` is 0, `fault_irq_n` is 1 and both latches are clear, so `pwm_out` equals `pwm_in` when no fault is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | NPH*CUR_W | Packed signed phase-current samples, phase 0 in the low bits |
| oc_limit | input | CUR_W | Unsigned current magnitude limit |
| temp_fault_n | input | 1 | Active-low over-temperature fault |
| chk_done | input | 1 | Insulation and leakage test finished |
| prechg_done | input | 1 | DC-link charge finished |
| relay_ack | input | 1 | Grid relay reported closed |
| clr | input | 1 | Lockout and halt clear command |
| pwm_in | input | GATE_N | Gate PWM lines from the modulator |
| pwm_out | output | GATE_N | Gated PWM lines to the drivers |
| relay_cmd | output | 1 | Grid relay close command |
| fault_irq_n | output | 1 | Active-low overcurrent interrupt |
| state | output | 3 | Sequencer state code |

## Verification
The per-cycle assertions cover several rules:
- gates are always off while the temperature line is low;
- the relay command is never present outside closing or running;
- a low interrupt without a clear is always followed by halt;
- running is only ever entered from closing;
- the state code never leaves its legal range.

Other behaviours show only in the bench's scenarios:
- the strict comparison at the limit and the most negative sample;
- the release of the latch only after the sources are quiet;
- the exact cycle at which each budget expires;
- the complete forward walk through the sequence.

// File: rtl/invg_pkg.sv
package invg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TEST   = 3'd1,
    ST_CHARGE = 3'd2,
    ST_CLOSE  = 3'd3,
    ST_ON     = 3'd4,
    ST_HALT   = 3'd5
  } seq_st_e;
endpackage

// File: rtl/invg_peak_mag.sv
module invg_peak_mag #(
  parameter int NPH   = 3,
  parameter int CUR_W = 12
) (
  input  logic [NPH*CUR_W-1:0] phase_i,
  output logic [CUR_W-1:0]     peak
);
  logic [CUR_W-1:0] mag [NPH];

  for (genvar p = 0; p < NPH; p++) begin : g_mag
    logic [CUR_W-1:0] raw;
    assign raw    = phase_i[p*CUR_W +: CUR_W];
    assign mag[p] = raw[CUR_W-1] ? (~raw + 1'b1) : raw;
  end

  always_comb begin
    peak = '0;
    for (int p = 0; p < NPH; p++) begin
      if (mag[p] > peak) peak = mag[p];
    end
  end
endmodule

// File: rtl/invg_lockout.sv
module invg_lockout (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_now,
  input  logic ot_now,
  input  logic clr,
  output logic block,
  output logic irq_n
);
  logic oc_lat, ot_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc_lat <= 1'b0;
      ot_lat <= 1'b0;
    end else if (clr && !oc_now && !ot_now) begin
      oc_lat <= 1'b0;
      ot_lat <= 1'b0;
    end else begin
      oc_lat <= oc_lat | oc_now;
      ot_lat <= ot_lat | ot_now;
    end
  end

  assign block = oc_now | ot_now | oc_lat | ot_lat;
  assign irq_n = ~(oc_now | oc_lat);
endmodule

// File: rtl/invg_sequencer.sv
module invg_sequencer
  import invg_pkg::*;
#(
  parameter int CHK_TMO = 1000,
  parameter int PCH_TMO = 1000,
  parameter int GC_TMO  = 1000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    oc_now,
  input  logic    ot_now,
  input  logic    locked,
  input  logic    clr,
  input  logic    chk_done,
  input  logic    prechg_done,
  input  logic    relay_ack,
  output seq_st_e st
);
  localparam int MAXT  = (CHK_TMO > PCH_TMO) ?
                         ((CHK_TMO > GC_TMO) ? CHK_TMO : GC_TMO) :
                         ((PCH_TMO > GC_TMO) ? PCH_TMO : GC_TMO);
  localparam int CNT_W = $clog2(MAXT + 1);

  seq_st_e          nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:   if (!locked) nxt = ST_TEST;
      ST_TEST:   if (chk_done) nxt = ST_CHARGE;
                 else if (cnt == CNT_W'(CHK_TMO - 1)) nxt = ST_IDLE;
      ST_CHARGE: if (prechg_done) nxt = ST_CLOSE;
                 else if (cnt == CNT_W'(PCH_TMO - 1)) nxt = ST_IDLE;
      ST_CLOSE:  if (relay_ack) nxt = ST_ON;
                 else if (cnt == CNT_W'(GC_TMO - 1)) nxt = ST_IDLE;
      ST_ON:     nxt = ST_ON;
      ST_HALT:   if (clr && !oc_now && !ot_now) nxt = ST_IDLE;
      default:   nxt = ST_HALT;
    endcase
    if (oc_now) nxt = ST_HALT;
    else if (ot_now && st != ST_HALT) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st <= nxt;
      if (nxt != st) cnt <= '0;
      else if (cnt != CNT_W'(MAXT)) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/inv_guard_seq.sv
module inv_guard_seq
  import invg_pkg::*;
#(
  parameter int NPH     = 3,
  parameter int CUR_W   = 12,
  parameter int GATE_N  = 6,
  parameter int CHK_TMO = 1000,
  parameter int PCH_TMO = 1000,
  parameter int GC_TMO  = 1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPH*CUR_W-1:0] phase_i,
  input  logic [CUR_W-1:0]     oc_limit,
  input  logic                 temp_fault_n,
  input  logic                 chk_done,
  input  logic                 prechg_done,
  input  logic                 relay_ack,
  input  logic                 clr,
  input  logic [GATE_N-1:0]    pwm_in,
  output logic [GATE_N-1:0]    pwm_out,
  output logic                 relay_cmd,
  output logic                 fault_irq_n,
  output logic [2:0]           state
);
  logic [CUR_W-1:0] peak;
  logic             oc_now, ot_now, block;
  seq_st_e          st;

  invg_peak_mag #(.NPH(NPH), .CUR_W(CUR_W)) u_peak (
    .phase_i (phase_i),
    .peak    (peak)
  );

  assign oc_now = peak > oc_limit;
  assign ot_now = ~temp_fault_n;

  invg_lockout u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .oc_now (oc_now),
    .ot_now (ot_now),
    .clr    (clr),
    .block  (block),
    .irq_n  (fault_irq_n)
  );

  invg_sequencer #(.CHK_TMO(CHK_TMO), .PCH_TMO(PCH_TMO), .GC_TMO(GC_TMO)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .oc_now      (oc_now),
    .ot_now      (ot_now),
    .locked      (block),
    .clr         (clr),
    .chk_done    (chk_done),
    .prechg_done (prechg_done),
    .relay_ack   (relay_ack),
    .st          (st)
  );

  assign pwm_out   = block ? '0 : pwm_in;
  assign relay_cmd = (st == ST_CLOSE || st == ST_ON) && !oc_now && !ot_now;
  assign state     = st;
endmodule

// File: rtl/invg_chk.sv
module invg_chk #(
  parameter int GATE_N = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              temp_fault_n,
  input logic              clr,
  input logic [GATE_N-1:0] pwm_out,
  input logic              relay_cmd,
  input logic              fault_irq_n,
  input logic [2:0]        state
);
  assert_temp_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_fault_n |-> pwm_out == '0);

  assert_relay_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    relay_cmd |-> (state == 3'd3 || state == 3'd4));

  assert_oc_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_irq_n && !clr) |=> state == 3'd5);

  assert_run_from_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && $past(state) != 3'd4) |-> $past(state) == 3'd3);

  assert_legal_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd5);
endmodule

bind inv_guard_seq invg_chk #(.GATE_N(GATE_N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .temp_fault_n (temp_fault_n),
  .clr          (clr),
  .pwm_out      (pwm_out),
  .relay_cmd    (relay_cmd),
  .fault_irq_n  (fault_irq_n),
  .state        (state)
);

// File: tb/inv_guard_seq_test.sv
`timescale 1ns/1ps
module inv_guard_seq_test;
  localparam int W = 12;
  localparam int G = 6;
  localparam int T = 8;
  localparam logic [G-1:0] PWM = 6'b101101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3*W-1:0] phase_i = '0;
  logic [W-1:0] oc_limit = 12'd1000;
  logic temp_fault_n = 1'b1, chk_done = 1'b0, prechg_done = 1'b0;
  logic relay_ack = 1'b0, clr = 1'b0;
  logic [G-1:0] pwm_in = PWM;
  logic [G-1:0] pwm_out;
  logic relay_cmd, fault_irq_n;
  logic [2:0] state;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  inv_guard_seq #(.NPH(3), .CUR_W(W), .GATE_N(G), .CHK_TMO(T), .PCH_TMO(T), .GC_TMO(T)) uut (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .oc_limit(oc_limit),
    .temp_fault_n(temp_fault_n), .chk_done(chk_done), .prechg_done(prechg_done),
    .relay_ack(relay_ack), .clr(clr), .pwm_in(pwm_in), .pwm_out(pwm_out),
    .relay_cmd(relay_cmd), .fault_irq_n(fault_irq_n), .state(state));

  // phase a, b, c, expected trip
  localparam logic [3*W:0] VEC [6] = '{
    {12'sd0,     12'sd0,     12'sd0,     1'b0},
    {12'sd1000, -12'sd1000,  12'sd500,   1'b0},
    {12'sd1001,  12'sd0,     12'sd0,     1'b1},
    {12'sd0,    -12'sd1001,  12'sd0,     1'b1},
    {12'sd0,     12'sd0,    -12'sd2048,  1'b1},
    {12'sd999,  -12'sd999,   12'sd999,   1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(); clr = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 state", state, 0);
    chk("R9 relay", relay_cmd, 0);
    chk("R9 irq", fault_irq_n, 1);
    chk("R9 pwm", pwm_out, PWM);
    rst_n = 1'b1;

    // R1/R2 vector table: magnitude peak vs limit
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      phase_i = {VEC[i][1 +: W], VEC[i][1+W +: W], VEC[i][1+2*W +: W]};
      #1;
      chk("R1 trip", !fault_irq_n, VEC[i][0]);
      chk("R2 pwm", pwm_out, VEC[i][0] ? 0 : PWM);
      @(negedge clk);
      phase_i = '0;
      pulse_clr();
    end

    // Fresh start for sequence
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    tick(); chk("R5 test", state, 1);
    chk_done = 1'b1; tick(); chk_done = 1'b0; chk("R5 charge", state, 2);
    chk("R6 relay off in charge", relay_cmd, 0);
    prechg_done = 1'b1; tick(); prechg_done = 1'b0; chk("R5 close", state, 3);
    chk("R6 relay closing", relay_cmd, 1);
    relay_ack = 1'b1; tick(); relay_ack = 1'b0; chk("R5 run", state, 4);
    chk("R6 relay run", relay_cmd, 1);

    // R3 temperature trip
    temp_fault_n = 1'b0; #1;
    chk("R3 pwm", pwm_out, 0);
    chk("R3 irq", fault_irq_n, 1);
    chk("R6 relay drop", relay_cmd, 0);
    tick(); chk("R8 temp to idle", state, 0);
    // R4 clear ignored while active
    clr = 1'b1; tick(); clr = 1'b0; temp_fault_n = 1'b1; #1;
    chk("R4 clr ignored", pwm_out, 0);
    tick(); chk("R4 latched idle", state, 0);
    chk("R4 still blocked", pwm_out, 0);
    pulse_clr();
    chk("R4 released", pwm_out, PWM);
    chk("R4 idle", state, 0);
    tick(); chk("R5 restart", state, 1);

    // R7 test timeout
    repeat (T - 1) tick();
    chk("R7 before expiry", state, 1);
    tick(); chk("R7 expiry", state, 0);
    tick(); chk("R5 re-enter", state, 1);

    // R2/R8 overcurrent to halt
    phase_i[W-1:0] = 12'd1500; #1;
    chk("R2 irq", fault_irq_n, 0);
    chk("R2 pwm", pwm_out, 0);
    tick(); chk("R8 halt", state, 5);
    phase_i = '0;
    tick(); chk("R8 halt held", state, 5);
    chk("R4 irq latched", fault_irq_n, 0);
    pulse_clr();
    chk("R8 halt left", state, 0);
    chk("R4 irq released", fault_irq_n, 1);

    // R7 closing timeout
    tick(); chk_done = 1'b1; tick(); chk_done = 1'b0;
    prechg_done = 1'b1; tick(); prechg_done = 1'b0;
    chk("R5 close again", state, 3);
    repeat (T - 1) tick();
    chk("R7 close before expiry", state, 3);
    tick(); chk("R7 close expiry", state, 0);
    chk("R6 relay off idle", relay_cmd, 0);

    summary();
  end
endmodule